// File: doc/BRIEF.md
# Idle-Driven SDRAM Low-Power Sequencer

This block sits beside the command path of a DDR memory controller and decides when the attached SDRAM should drop into a low-power state. It counts consecutive clock cycles in which the controller reports no pending work. When that count reaches a programmed threshold, it issues a one-cycle request to enter either power-down or self-refresh, as the active mode selects. Each of the two states has its own threshold.

Every incoming request clears the idle count. If the SDRAM is in a low-power state when a request arrives, the block first issues a one-cycle exit request. It passes the request on one cycle after that. Mode and thresholds are written into a shadow copy. The shadow is moved into the active copy only while the sequencer is in its normal, non-low-power state, so the rules in force never change during a low-power stay. Clock-enable pin timing, refresh scheduling and command encoding belong to other blocks.

Top module: `sdram_lp_seq`

## Requirements
- R1: After reset, `lp_state_o` is 0 (normal), all pulse outputs are low, and the active mode is disabled.
- R2: Active mode 1 selects power-down and mode 2 selects self-refresh. Every other mode value (0, 3 to 7) prevents any automatic entry, however long the bus stays idle.
- R3: A 4-bit threshold code c stands for an idle window of 16·2^c cycles. The entry pulse is high in the cycle after the edge at which the window's last consecutive idle cycle is sampled.
- R4: A cycle with `idle_i` low restarts the idle count from zero, and so does a cycle with `new_req_i` high.
- R5: In power-down mode, entry raises `pd_enter_o` for one cycle and sets `lp_state_o` to 1, using the power-down threshold. In self-refresh mode, entry raises `sr_enter_o` and sets `lp_state_o` to 2, using the self-refresh threshold. While in either state, the state holds until a request arrives.
- R6: A request in a low-power state raises `exit_o` for one cycle in the next cycle, with `lp_state_o` back at 0. `req_o` follows one cycle after `exit_o`.
- R7: A request in the normal state appears on `req_o` one cycle later, without `exit_o`. Requests are strobes at least two cycles apart.
- R8: A configuration write lands in the shadow copy. It becomes active at the first edge after the write at which the state is normal, and that copy restarts the idle count. While a low-power state is held, the active settings do not change.
- R9: `pd_enter_o`, `sr_enter_o` and `exit_o` are single-cycle pulses, and at most one of them is high at a time.
- R10: A request that arrives in the very cycle the threshold would be reached cancels that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | High while the controller has no pending work |
| new_req_i | input | 1 | One-cycle strobe for a new command |
| cfg_wr_i | input | 1 | Writes the three configuration fields into the shadow copy |
| cfg_mode_i | input | 3 | Mode: 1 power-down, 2 self-refresh, other values disabled |
| cfg_pd_code_i | input | 4 | Power-down threshold code |
| cfg_sr_code_i | input | 4 | Self-refresh threshold code |
| pd_enter_o | output | 1 | Request to enter power-down |
| sr_enter_o | output | 1 | Request to enter self-refresh |
| exit_o | output | 1 | Request to leave the low-power state |
| req_o | output | 1 | Request passed on to the controller |
| lp_state_o | output | 2 | 0 normal, 1 power-down, 2 self-refresh |

## Verification
After a write, the active settings change at the next rising edge. An entry pulse is due exactly 16·2^c rising edges after that copy edge, or after the last non-idle or request cycle. `exit_o` is due one edge after a request in a low-power state, and `req_o` one edge later still. In the normal state, `req_o` is due one edge after the request. The bench drives inputs at falling edges and counts whole cycles to the edge in question. It samples one cycle short of each due edge to show that nothing fired early, then samples at the due edge. In the random phase, a bench model stepped on the same edges supplies the expected value of every output each cycle.

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq #(
  parameter int MODE_W     = 3,
  parameter int CODE_W     = 4,
  parameter int BASE_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_i,
  input  logic              new_req_i,
  input  logic              cfg_wr_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic [CODE_W-1:0] cfg_pd_code_i,
  input  logic [CODE_W-1:0] cfg_sr_code_i,
  output logic              pd_enter_o,
  output logic              sr_enter_o,
  output logic              exit_o,
  output logic              req_o,
  output logic [1:0]        lp_state_o
);

  localparam int CNT_W = BASE_SHIFT + (1 << CODE_W);
  localparam logic [MODE_W-1:0] MODE_PD = MODE_W'(1);
  localparam logic [MODE_W-1:0] MODE_SR = MODE_W'(2);

  typedef enum logic [1:0] {ST_NORM = 2'd0, ST_PD = 2'd1, ST_SR = 2'd2} lp_state_t;

  lp_state_t         state;
  logic [MODE_W-1:0] shd_mode, act_mode;
  logic [CODE_W-1:0] shd_pd, shd_sr, act_pd, act_sr;
  logic              shd_pend, req_hold;
  logic [CNT_W-1:0]  idle_cnt, limit;

  wire copy_now = shd_pend && (state == ST_NORM);
  wire mode_pd  = (act_mode == MODE_PD);
  wire mode_sr  = (act_mode == MODE_SR);
  wire auto_on  = mode_pd || mode_sr;
  wire [CODE_W-1:0] sel_code = mode_sr ? act_sr : act_pd;

  assign limit = CNT_W'(1) << (BASE_SHIFT + 32'(sel_code));

  wire hit     = (idle_cnt == limit - CNT_W'(1));
  wire counting = (state == ST_NORM) && !copy_now && auto_on && idle_i && !new_req_i;
  wire go_low  = counting && hit;

  assign lp_state_o = state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_mode <= '0;
      shd_pd   <= '0;
      shd_sr   <= '0;
      shd_pend <= 1'b0;
      act_mode <= '0;
      act_pd   <= '0;
      act_sr   <= '0;
    end else begin
      if (cfg_wr_i) begin
        shd_mode <= cfg_mode_i;
        shd_pd   <= cfg_pd_code_i;
        shd_sr   <= cfg_sr_code_i;
        shd_pend <= 1'b1;
      end else if (copy_now) begin
        shd_pend <= 1'b0;
      end
      if (copy_now) begin
        act_mode <= shd_mode;
        act_pd   <= shd_pd;
        act_sr   <= shd_sr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_cnt <= '0;
    else if (!counting || hit) idle_cnt <= '0;
    else idle_cnt <= idle_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_NORM;
      pd_enter_o <= 1'b0;
      sr_enter_o <= 1'b0;
      exit_o     <= 1'b0;
      req_o      <= 1'b0;
      req_hold   <= 1'b0;
    end else begin
      pd_enter_o <= 1'b0;
      sr_enter_o <= 1'b0;
      exit_o     <= 1'b0;
      req_hold   <= 1'b0;
      req_o      <= req_hold || ((state == ST_NORM) && new_req_i);
      case (state)
        ST_NORM: if (go_low) begin
          state      <= mode_sr ? ST_SR : ST_PD;
          pd_enter_o <= mode_pd;
          sr_enter_o <= mode_sr;
        end
        default: if (new_req_i) begin
          state    <= ST_NORM;
          exit_o   <= 1'b1;
          req_hold <= 1'b1;
        end
      endcase
    end
  end

  assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pd_enter_o, sr_enter_o, exit_o})) else $error("R9 events overlap");

  assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_enter_o || sr_enter_o) |=> !(pd_enter_o || sr_enter_o)) else $error("R9 entry pulse too wide");

  assert_pd_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pd_enter_o |-> (lp_state_o == 2'd1)) else $error("R5 power-down state");

  assert_sr_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter_o |-> (lp_state_o == 2'd2)) else $error("R5 self-refresh state");

  assert_exit_then_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exit_o |=> req_o) else $error("R6 request not forwarded after exit");

  assert_exit_from_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exit_o |-> (lp_state_o == 2'd0) && ($past(lp_state_o) != 2'd0)) else $error("R6 exit without low state");

  assert_disabled_no_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_NORM) && !auto_on) |=> !(pd_enter_o || sr_enter_o)) else $error("R2 entry while disabled");

  assert_req_blocks_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_NORM) && new_req_i) |=> !(pd_enter_o || sr_enter_o)) else $error("R10 entry despite request");

  assert_active_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_NORM) |=> ($stable(act_mode) && $stable(act_pd) && $stable(act_sr)))
    else $error("R8 active settings changed in low-power state");

endmodule

// File: tb/sdram_lp_seq_bench.sv
`timescale 1ns/1ps
module sdram_lp_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic idle_i = 1'b0, new_req_i = 1'b0, cfg_wr_i = 1'b0;
  logic [2:0] cfg_mode_i = '0;
  logic [3:0] cfg_pd_code_i = '0, cfg_sr_code_i = '0;
  logic pd_enter_o, sr_enter_o, exit_o, req_o;
  logic [1:0] lp_state_o;

  int n_tests = 0, n_fail = 0, n_enter = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  sdram_lp_seq u_sdram_lp_seq (
    .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .new_req_i(new_req_i),
    .cfg_wr_i(cfg_wr_i), .cfg_mode_i(cfg_mode_i), .cfg_pd_code_i(cfg_pd_code_i),
    .cfg_sr_code_i(cfg_sr_code_i), .pd_enter_o(pd_enter_o), .sr_enter_o(sr_enter_o),
    .exit_o(exit_o), .req_o(req_o), .lp_state_o(lp_state_o)
  );

  function automatic int window_of(input logic [3:0] code);
    return 16 << code;
  endfunction

  int m_st, m_cnt, m_amode, m_apd, m_asr, m_smode, m_spd, m_ssr;
  bit m_pend, m_hold, e_pd, e_sr, e_exit, e_req;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_amode = 0; m_apd = 0; m_asr = 0;
      m_smode = 0; m_spd = 0; m_ssr = 0; m_pend = 0; m_hold = 0;
      e_pd = 0; e_sr = 0; e_exit = 0; e_req = 0;
    end else begin
      e_pd = 0; e_sr = 0; e_exit = 0; e_req = m_hold; m_hold = 0;
      if (m_st == 0) begin
        if (new_req_i) e_req = 1;
        if (m_pend) begin
          m_amode = m_smode; m_apd = m_spd; m_asr = m_ssr; m_pend = 0; m_cnt = 0;
        end else if (new_req_i || !idle_i || !(m_amode == 1 || m_amode == 2)) begin
          m_cnt = 0;
        end else if (m_cnt == window_of(4'((m_amode == 2) ? m_asr : m_apd)) - 1) begin
          m_cnt = 0; m_st = m_amode;
          if (m_amode == 1) e_pd = 1; else e_sr = 1;
        end else m_cnt++;
      end else if (new_req_i) begin
        m_st = 0; e_exit = 1; m_hold = 1;
      end
      if (cfg_wr_i) begin
        m_smode = cfg_mode_i; m_spd = cfg_pd_code_i; m_ssr = cfg_sr_code_i; m_pend = 1;
      end
    end
  end

  always @(negedge clk) if (rst_n && (pd_enter_o || sr_enter_o)) n_enter++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [2:0] m, input logic [3:0] p, input logic [3:0] s);
    cfg_wr_i = 1; cfg_mode_i = m; cfg_pd_code_i = p; cfg_sr_code_i = s;
    cyc(1);
    cfg_wr_i = 0;
  endtask

  task automatic req_pulse();
    new_req_i = 1; cyc(1); new_req_i = 0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
  end

  initial begin
    int n0;
    bit prev_req;
    void'($urandom(32'd20240611));
    cyc(3);
    rst_n = 1;
    chk("R1", "state", lp_state_o, 0);
    chk("R1", "pulses", {pd_enter_o, sr_enter_o, exit_o, req_o}, 0);
    idle_i = 1;
    cyc(40);
    chk("R1", "disabled after reset", n_enter, 0);

    cfg(3'd1, 4'd0, 4'd1); cyc(1); cyc(15);
    chk("R3", "pd early", pd_enter_o, 0);
    cyc(1);
    chk("R3", "pd at window", pd_enter_o, 1);
    chk("R5", "pd state", lp_state_o, 1);
    chk("R5", "no sr", sr_enter_o, 0);
    cyc(1);
    chk("R9", "pd pulse width", pd_enter_o, 0);
    cyc(40);
    chk("R5", "pd held", lp_state_o, 1);
    req_pulse();
    chk("R6", "exit", exit_o, 1);
    chk("R6", "state normal", lp_state_o, 0);
    chk("R6", "req not yet", req_o, 0);
    cyc(1);
    chk("R6", "req after exit", req_o, 1);
    chk("R9", "exit width", exit_o, 0);

    cfg(3'd2, 4'd0, 4'd1); cyc(1); cyc(31);
    chk("R5", "sr early", sr_enter_o, 0);
    cyc(1);
    chk("R5", "sr at window", sr_enter_o, 1);
    chk("R5", "sr state", lp_state_o, 2);
    chk("R9", "no pd with sr", pd_enter_o, 0);
    req_pulse();
    chk("R6", "sr exit", exit_o, 1);
    cyc(1);

    cfg(3'd1, 4'd0, 4'd0); cyc(1); cyc(10);
    idle_i = 0; cyc(1); idle_i = 1;
    cyc(15);
    chk("R4", "busy restarts count", pd_enter_o, 0);
    cyc(1);
    chk("R4", "entry after full idle", pd_enter_o, 1);
    req_pulse(); cyc(1);

    cfg(3'd1, 4'd0, 4'd0); cyc(1); cyc(10);
    req_pulse();
    chk("R7", "req normal", req_o, 1);
    chk("R7", "no exit in normal", exit_o, 0);
    cyc(15);
    chk("R4", "request restarts count", pd_enter_o, 0);
    cyc(1);
    chk("R4", "entry after request gap", pd_enter_o, 1);
    req_pulse(); cyc(1);

    cfg(3'd1, 4'd0, 4'd0); cyc(1); cyc(15);
    new_req_i = 1; cyc(1); new_req_i = 0;
    chk("R10", "entry cancelled", pd_enter_o, 0);
    chk("R10", "still normal", lp_state_o, 0);
    chk("R7", "req forwarded", req_o, 1);
    cyc(1);
    chk("R10", "no late entry", pd_enter_o, 0);
    cyc(1);

    cfg(3'd0, 4'd0, 4'd0); cyc(1);
    n0 = n_enter; cyc(100);
    chk("R2", "mode 0 no entry", n_enter, n0);
    cfg(3'd3, 4'd0, 4'd0); cyc(60);
    chk("R2", "mode 3 no entry", n_enter, n0);
    cfg(3'd5, 4'd0, 4'd0); cyc(60);
    chk("R2", "mode 5 no entry", n_enter, n0);
    cfg(3'd7, 4'd0, 4'd0); cyc(60);
    chk("R2", "mode 7 no entry", n_enter, n0);
    chk("R2", "state normal", lp_state_o, 0);

    cfg(3'd1, 4'd0, 4'd0); cyc(1); cyc(16);
    chk("R8", "pd entered", lp_state_o, 1);
    cfg(3'd2, 4'd0, 4'd0); cyc(40);
    chk("R8", "write held in shadow", lp_state_o, 1);
    chk("R8", "no sr while pd", sr_enter_o, 0);
    req_pulse();
    chk("R8", "exit", exit_o, 1);
    cyc(1); cyc(15);
    chk("R8", "sr not early", sr_enter_o, 0);
    cyc(1);
    chk("R8", "new mode applied", sr_enter_o, 1);
    chk("R8", "sr state", lp_state_o, 2);
    req_pulse(); cyc(1);

    prev_req = 0;
    for (int i = 0; i < 4000; i++) begin
      if (cmp_on) begin
        chk("R5", "rand pd_enter", pd_enter_o, e_pd);
        chk("R5", "rand sr_enter", sr_enter_o, e_sr);
        chk("R6", "rand exit", exit_o, e_exit);
        chk("R7", "rand req", req_o, e_req);
        chk("R3", "rand state", lp_state_o, m_st);
      end
      cmp_on = 1;
      idle_i = ($urandom_range(99) < 90);
      new_req_i = !prev_req && ($urandom_range(99) < 2);
      prev_req = new_req_i;
      cfg_wr_i = ($urandom_range(199) < 2);
      cfg_mode_i = 3'($urandom_range(3));
      cfg_pd_code_i = 4'($urandom_range(2));
      cfg_sr_code_i = 4'($urandom_range(2));
      cyc(1);
    end
    summary();
  end
endmodule